// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block steps through the column addresses of one burst inside a row that is already open. A memory controller gives it a start column, a length code and an ordering choice with a single-cycle start pulse. From the next cycle on, the block presents the current column together with a valid flag. Each cycle in which the controller raises the advance input, the block moves to the next column of the burst. Only the first column comes from outside. The rest come from an internal beat counter.

Fixed-length bursts of 1, 2, 4 or 8 beats stay inside the aligned group of columns that holds the start column. They wrap inside that group in either sequential or interleaved order. A full-page burst walks the whole row, wraps from the top column to column 0, and runs until the terminate input ends it. A new start pulse is accepted on any cycle, including in the middle of a burst. This lets the controller issue a fresh column on every cycle for random column access.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is low, and after its release until the first start pulse, `beatValid` and `lastBeat` are low.
- R2: One cycle after `startValid` is sampled high, `beatValid` is high and `colOut` equals the sampled `startCol`. The `blCode` encoding is: 0 = 1 beat, 1 = 2 beats, 2 = 4 beats, 3 = 8 beats, 7 = full page. Codes 4, 5 and 6 behave as 1 beat.
- R3: With `burstType` = 0 and burst length N, beat k has the column bits above log2(N) equal to those of the start column. Its low log2(N) bits equal (start low bits + k) mod N.
- R4: With `burstType` = 1 and length 2, 4 or 8, beat k keeps the upper bits of the start column. Its low log2(N) bits are the start low bits XOR k. For full page and 1-beat bursts, `burstType` has no effect.
- R5: While a burst is active and `advance` is low, `colOut` and `lastBeat` hold their values and the burst stays active.
- R6: `lastBeat` is high exactly on the final beat of a fixed-length burst. If `advance` is high on that beat, `beatValid` is low on the next cycle.
- R7: A 1-beat burst shows only the start column and raises `lastBeat` on that same beat.
- R8: A full-page burst increments through all 256 columns, wrapping from 255 to 0, and never raises `lastBeat`.
- R9: If `terminate` is high during an active burst, in any mode, `beatValid` is low on the next cycle.
- R10: A start pulse during an active burst restarts the burst at the new column with the new length and order. A start pulse takes priority over `advance` and `terminate` sampled in the same cycle.
- R11: `advance` and `terminate` have no effect while no burst is active: `beatValid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| startValid | input | 1 | Load a start column and begin a burst |
| startCol | input | 8 | Column at which the burst begins |
| blCode | input | 3 | Burst length code (see R2) |
| burstType | input | 1 | 0 = sequential, 1 = interleaved |
| advance | input | 1 | Move to the next beat |
| terminate | input | 1 | End the active burst |
| colOut | output | 8 | Column of the current beat |
| beatValid | output | 1 | A burst beat is being presented |
| lastBeat | output | 1 | Current beat is the final one of a fixed-length burst |

## Verification
A reload can land in the same cycle as a step or a burst end. In that case the start pulse, `advance` and `terminate` are all sampled together. The bench provokes this by raising `startValid` in the middle of a burst while both `advance` and `terminate` are held high, and also on the final beat of a fixed burst. A behavioural reference model gives the load strict priority. It is compared with `beatValid`, `colOut` and `lastBeat` on every clock, so a step or stop that wins over the load shows up as a wrong column or a missing beat on the following cycle.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  // strobes from the control to the datapath
  typedef struct packed {
    logic load;  // capture a new start column, clear beat count
    logic step;  // move to the next beat
  } colCtrl_t;
endpackage

// File: rtl/burst_col_ctrl.sv
module burst_col_ctrl
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8,
  localparam int LOG_W = $clog2(COL_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic [2:0]       blCode,
  input  logic             burstType,
  input  logic             advance,
  input  logic             terminate,
  input  logic             finalBeat,
  output colCtrl_t         ctrlOut,
  output logic [LOG_W-1:0] lenLog,
  output logic             ilvMode,
  output logic             beatValid,
  output logic             lastBeat
);

  logic             activeQ;
  logic             fullPageQ;
  logic [LOG_W-1:0] lenLogQ;
  logic             ilvQ;
  logic [LOG_W-1:0] codeLog;
  logic             codeFull;
  logic             codeIlvOk;
  logic             fixedEnd;

  always_comb begin
    codeFull  = 1'b0;
    codeIlvOk = 1'b0;
    unique case (blCode)
      3'd1:    begin codeLog = LOG_W'(1); codeIlvOk = 1'b1; end
      3'd2:    begin codeLog = LOG_W'(2); codeIlvOk = 1'b1; end
      3'd3:    begin codeLog = LOG_W'(3); codeIlvOk = 1'b1; end
      3'd7:    begin codeLog = LOG_W'(COL_W); codeFull = 1'b1; end
      default: codeLog = '0;
    endcase
  end

  assign fixedEnd     = finalBeat && !fullPageQ;
  assign ctrlOut.load = startValid;
  assign ctrlOut.step = activeQ && advance && !startValid && !terminate && !fixedEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ   <= 1'b0;
      fullPageQ <= 1'b0;
      lenLogQ   <= '0;
      ilvQ      <= 1'b0;
    end else if (startValid) begin
      activeQ   <= 1'b1;
      fullPageQ <= codeFull;
      lenLogQ   <= codeLog;
      ilvQ      <= burstType && codeIlvOk;
    end else if (activeQ && (terminate || (advance && fixedEnd))) begin
      activeQ <= 1'b0;
    end
  end

  assign lenLog    = lenLogQ;
  assign ilvMode   = ilvQ;
  assign beatValid = activeQ;
  assign lastBeat  = activeQ && fixedEnd;

  // R6
  fixed_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lastBeat && advance && !startValid) |=> !beatValid);

  // R9
  term_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && terminate && !startValid) |=> !beatValid);

  // R7
  single_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && blCode == 3'd0) |=> (beatValid && lastBeat));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!beatValid && !startValid) |=> !beatValid);

endmodule

// File: rtl/burst_col_dp.sv
module burst_col_dp
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8,
  localparam int LOG_W = $clog2(COL_W + 1),
  localparam int EXT_W = COL_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  colCtrl_t         ctrlIn,
  input  logic [COL_W-1:0] startCol,
  input  logic [LOG_W-1:0] lenLog,
  input  logic             ilvMode,
  output logic [COL_W-1:0] colOut,
  output logic             finalBeat
);

  logic [COL_W-1:0] baseCol;
  logic [COL_W-1:0] beatCnt;
  logic [EXT_W-1:0] spanOne;
  logic [COL_W-1:0] lowMask;
  logic [COL_W-1:0] lowBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseCol <= '0;
      beatCnt <= '0;
    end else if (ctrlIn.load) begin
      baseCol <= startCol;
      beatCnt <= '0;
    end else if (ctrlIn.step) begin
      beatCnt <= beatCnt + COL_W'(1);
    end
  end

  assign spanOne = EXT_W'(1) << lenLog;
  assign lowMask = COL_W'(spanOne - EXT_W'(1));

  always_comb begin
    if (ilvMode) lowBits = baseCol ^ beatCnt;
    else         lowBits = baseCol + beatCnt;
  end

  assign colOut    = (baseCol & ~lowMask) | (lowBits & lowMask);
  assign finalBeat = (beatCnt == lowMask);

  // R2
  reload_col_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlIn.load |=> (colOut == $past(startCol)));

  // R3
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlIn.step |=> ((colOut & ~lowMask) == ($past(colOut) & ~$past(lowMask))));

  // R5
  hold_col_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlIn.load && !ctrlIn.step) |=> $stable(colOut));

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8,
  localparam int LOG_W = $clog2(COL_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       blCode,
  input  logic             burstType,
  input  logic             advance,
  input  logic             terminate,
  output logic [COL_W-1:0] colOut,
  output logic             beatValid,
  output logic             lastBeat
);

  colCtrl_t         ctrlBus;
  logic [LOG_W-1:0] lenLog;
  logic             ilvMode;
  logic             finalBeat;

  burst_col_ctrl #(.COL_W(COL_W)) uCtrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .blCode(blCode),
    .burstType(burstType), .advance(advance), .terminate(terminate),
    .finalBeat(finalBeat), .ctrlOut(ctrlBus), .lenLog(lenLog),
    .ilvMode(ilvMode), .beatValid(beatValid), .lastBeat(lastBeat)
  );

  burst_col_dp #(.COL_W(COL_W)) uDp (
    .clk(clk), .rstN(rstN), .ctrlIn(ctrlBus), .startCol(startCol),
    .lenLog(lenLog), .ilvMode(ilvMode), .colOut(colOut), .finalBeat(finalBeat)
  );

endmodule

// File: tb/tb_burst_col_gen.sv
module tb_burst_col_gen;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startValid = 1'b0;
  logic [7:0] startCol = '0;
  logic [2:0] blCode = '0;
  logic       burstType = 1'b0;
  logic       advance = 1'b0;
  logic       terminate = 1'b0;
  logic [7:0] colOut;
  logic       beatValid;
  logic       lastBeat;

  int checks = 0;
  int failures = 0;
  string tag = "R1";

  // reference model state
  bit refActive = 0;
  int refBase = 0, refBeat = 0, refLen = 1;
  bit refIlv = 0;

  always #5 clk = ~clk;

  burst_col_gen dut (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startCol(startCol),
    .blCode(blCode), .burstType(burstType), .advance(advance),
    .terminate(terminate), .colOut(colOut), .beatValid(beatValid),
    .lastBeat(lastBeat)
  );

  function automatic int lenOf(input logic [2:0] c);
    case (c)
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd7: return 256;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) refActive = 0;
    else if (startValid) begin
      refActive = 1; refBase = startCol; refBeat = 0;
      refLen = lenOf(blCode);
      refIlv = burstType && refLen >= 2 && refLen <= 8;
    end else if (refActive) begin
      if (terminate) refActive = 0;
      else if (advance) begin
        if (refLen != 256 && refBeat == refLen - 1) refActive = 0;
        else refBeat = (refBeat + 1) % 256;
      end
    end
  end

  function automatic int expCol();
    int off, grp;
    if (refLen == 256) return (refBase + refBeat) % 256;
    off = refBase % refLen;
    grp = refBase - off;
    if (refIlv) return grp + (off ^ refBeat);
    return grp + ((off + refBeat) % refLen);
  endfunction

  task automatic compare();
    bit eLast;
    eLast = refActive && refLen != 256 && refBeat == refLen - 1;
    checks++;
    if (beatValid !== refActive) begin
      failures++;
      $display("FAIL %s beatValid actual=%0b expected=%0b", tag, beatValid, refActive);
    end else if (refActive && (colOut !== 8'(expCol()) || lastBeat !== eLast)) begin
      failures++;
      $display("FAIL %s col/last actual=%0d/%0b expected=%0d/%0b",
               tag, colOut, lastBeat, expCol(), eLast);
    end else if (!refActive && lastBeat !== 1'b0) begin
      failures++;
      $display("FAIL %s lastBeat idle actual=%0b expected=0", tag, lastBeat);
    end
  endtask

  // one cycle: check outputs, then drive next inputs
  task automatic cyc(input bit sv, input int col, input int bl, input bit ty,
                     input bit adv, input bit term);
    @(negedge clk);
    if (rstN) compare();
    startValid = sv; startCol = 8'(col); blCode = 3'(bl);
    burstType = ty; advance = adv; terminate = term;
  endtask

  task automatic burst(input int col, input int bl, input bit ty, input int n);
    cyc(1, col, bl, ty, 0, 0);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 1, 0);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    checks++;
    if (beatValid !== 1'b0 || lastBeat !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset actual=%0b%0b expected=00", beatValid, lastBeat);
    end
    rstN = 1'b1;
    tag = "R1"; repeat (2) cyc(0, 0, 0, 0, 0, 0);
    tag = "R11"; cyc(0, 0, 0, 0, 1, 0); cyc(0, 0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 1, 1);
    tag = "R3"; burst(8'h0E, 2, 0, 5); burst(8'h35, 3, 0, 9); burst(8'h41, 1, 0, 3);
    tag = "R4"; burst(8'h35, 3, 1, 9); burst(8'h0E, 2, 1, 5); burst(8'h93, 1, 1, 3);
    tag = "R2"; burst(8'h22, 5, 0, 2); burst(8'h23, 6, 1, 2);
    tag = "R7"; burst(8'h80, 0, 1, 2);
    tag = "R5";
    cyc(1, 8'h5B, 3, 0, 0, 0);
    for (int i = 0; i < 20; i++) cyc(0, 0, 0, 0, i % 3 == 0, 0);
    tag = "R8"; burst(8'hFA, 7, 1, 262);
    tag = "R9"; cyc(0, 0, 0, 0, 1, 1); cyc(0, 0, 0, 0, 0, 0);
    cyc(1, 8'h10, 3, 0, 1, 0); cyc(0, 0, 0, 0, 1, 0); cyc(0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 1, 0);
    tag = "R10";
    cyc(1, 8'h18, 3, 0, 0, 0); cyc(0, 0, 0, 0, 1, 0); cyc(0, 0, 0, 0, 1, 0);
    cyc(1, 8'hC6, 2, 1, 1, 1); cyc(0, 0, 0, 0, 1, 0);
    cyc(1, 8'h07, 7, 0, 1, 1); cyc(0, 0, 0, 0, 1, 0);
    cyc(1, 8'h31, 1, 0, 1, 0); cyc(0, 0, 0, 0, 1, 0);
    cyc(1, 8'h64, 0, 0, 1, 1);
    cyc(1, 8'hE9, 2, 0, 1, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1, 0);
    cyc(1, 8'hAA, 1, 1, 1, 0);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule